// File: doc/BRIEF.md
# Loopback Transmit/Receive FIFO Channel

This block is one data channel with two 256-word queues. The host writes words into the transmit queue and takes words out of the receive queue. On the far side, a line interface can drain the transmit queue and fill the receive queue. A single 32-bit control word configures the channel. It holds a loopback enable, a synchronous clear for each queue, a low-water level for transmit, a high-water level for receive, and an interrupt enable and force pair.

When loopback is on, the channel moves the head word of the transmit queue into the receive queue on every clock in which the receive queue has room. While loopback is on, the line interface has no access to either queue. The threshold flags and the interrupt are derived combinationally from the current queue occupancy and the control word. This makes them usable both for host polling and as an interrupt request.

Top module: `lbk_chan`

## Requirements
- R1: After reset the control word reads 0, both counts are 0, both empty flags are 1, both full flags are 0 and the interrupt is 0.
- R2: A control write takes effect on the next clock. The spare bits 29, 28 and 3 read back as 0, and every other bit reads back as written. Bit 31 clears receive, bit 30 clears transmit, bits 27:16 hold the receive high-water level, bits 15:4 hold the transmit low-water level, bit 2 forces the interrupt, bit 1 enables the interrupt and bit 0 enables loopback.
- R3: With loopback off, words pushed by the host stay in the transmit queue until the line interface pops them, and they leave in first-in first-out order.
- R4: With loopback on, exactly one word per clock moves from the transmit head to the receive tail, in order, while transmit is not empty and receive is not full. The move stalls while receive is full and resumes on the clock after space appears.
- R5: While loopback is on, line pops of the transmit queue and line pushes into the receive queue are ignored.
- R6: The transmit low-water flag is 1 when the transmit count is less than or equal to the 12-bit level. The receive high-water flag is 1 when the receive count is greater than or equal to the 12-bit level.
- R7: A push to a full queue and a pop from an empty queue are dropped, and the count is left unchanged.
- R8: While a queue's clear bit is 1, that queue shows count 0, empty 1 and full 0, and it ignores pushes. The queue is still empty after the bit returns to 0.
- R9: The interrupt is the OR of force, transmit low-water and receive high-water, gated by the enable bit. When the enable bit is 0, the interrupt is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 32 | Control word write data |
| reg_rdata_o | output | 32 | Control word read-back |
| host_push_i | input | 1 | Host push into transmit queue |
| host_wdata_i | input | DW | Host push data |
| host_pop_i | input | 1 | Host pop from receive queue |
| host_rdata_o | output | DW | Receive queue head word |
| line_pop_i | input | 1 | Line pop from transmit queue |
| line_rdata_o | output | DW | Transmit queue head word |
| line_push_i | input | 1 | Line push into receive queue |
| line_wdata_i | input | DW | Line push data |
| tx_count_o | output | AW+1 | Transmit occupancy |
| rx_count_o | output | AW+1 | Receive occupancy |
| tx_empty_o | output | 1 | Transmit empty |
| tx_full_o | output | 1 | Transmit full |
| rx_empty_o | output | 1 | Receive empty |
| rx_full_o | output | 1 | Receive full |
| tx_aempty_o | output | 1 | Transmit low-water flag |
| rx_afull_o | output | 1 | Receive high-water flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The checker assumes the following about the inputs:
- A control write never lands on the same clock as the transfer or overflow cases it checks, so those properties exclude cycles in which reg_we_i is high.
- A host pop is the only other thing that can change the receive count during a loopback move.

The stimulus respects these assumptions:
- Control writes are issued as single isolated strobes.
- Host and line strobes are driven one at a time, on the falling edge.
- Loopback moves are observed only in cycles where no host pop is active, except for the one stall-release case, which the bench checks directly at the ports.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned LVL_W = 12;

  // spare bits 29:28 and 3 are held at zero
  localparam logic [REG_W-1:0] REG_KEEP = 32'hCFFF_FFF7;

  typedef struct packed {
    logic             rx_clr;
    logic             tx_clr;
    logic [LVL_W-1:0] rx_hi_lvl;
    logic [LVL_W-1:0] tx_lo_lvl;
    logic             irq_force;
    logic             irq_en;
    logic             loop_en;
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(input logic [REG_W-1:0] r);
    ctrl_t c;
    c.rx_clr    = r[31];
    c.tx_clr    = r[30];
    c.rx_hi_lvl = r[27:16];
    c.tx_lo_lvl = r[15:4];
    c.irq_force = r[2];
    c.irq_en    = r[1];
    c.loop_en   = r[0];
    return c;
  endfunction
endpackage

// File: rtl/lbk_ctrl_reg.sv
module lbk_ctrl_reg
  import lbk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output ctrl_t            ctrl_o
);
  logic [REG_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (we_i) q <= wdata_i & REG_KEEP;
  end

  assign rdata_o = q;
  assign ctrl_o  = decode_ctrl(q);
endmodule

// File: rtl/lbk_fifo.sv
module lbk_fifo #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [AW:0]   count_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam logic [AW:0] CNT_MAX = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   cnt;
  logic          is_full, is_empty, do_push, do_pop;

  assign is_full  = (cnt == CNT_MAX);
  assign is_empty = (cnt == '0);
  assign do_push  = push_i && !is_full && !clr_i;
  assign do_pop   = pop_i && !is_empty && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end

  // held-clear state is visible at once, before the pointers settle
  assign rdata_o = mem[rd_ptr];
  assign count_o = clr_i ? '0 : cnt;
  assign empty_o = clr_i | is_empty;
  assign full_o  = !clr_i & is_full;
endmodule

// File: rtl/lbk_xfer.sv
module lbk_xfer (
  input  logic loop_en_i,
  input  logic tx_clr_i,
  input  logic rx_clr_i,
  input  logic tx_empty_i,
  input  logic rx_full_i,
  input  logic line_pop_i,
  input  logic line_push_i,
  output logic tx_pop_o,
  output logic rx_push_o,
  output logic rx_from_tx_o
);
  logic move;

  assign move         = loop_en_i && !tx_empty_i && !rx_full_i && !tx_clr_i && !rx_clr_i;
  // loopback owns both queue ends facing the line
  assign tx_pop_o     = loop_en_i ? move : line_pop_i;
  assign rx_push_o    = loop_en_i ? move : line_push_i;
  assign rx_from_tx_o = loop_en_i;
endmodule

// File: rtl/lbk_flags.sv
module lbk_flags
  import lbk_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic [AW:0]      tx_count_i,
  input  logic [AW:0]      rx_count_i,
  input  logic [LVL_W-1:0] tx_lo_lvl_i,
  input  logic [LVL_W-1:0] rx_hi_lvl_i,
  input  logic             irq_en_i,
  input  logic             irq_force_i,
  output logic             tx_aempty_o,
  output logic             rx_afull_o,
  output logic             irq_o
);
  logic [LVL_W-1:0] tx_cnt_x, rx_cnt_x;

  assign tx_cnt_x    = LVL_W'(tx_count_i);
  assign rx_cnt_x    = LVL_W'(rx_count_i);
  assign tx_aempty_o = (tx_cnt_x <= tx_lo_lvl_i);
  assign rx_afull_o  = (rx_cnt_x >= rx_hi_lvl_i);
  assign irq_o       = irq_en_i & (irq_force_i | tx_aempty_o | rx_afull_o);
endmodule

// File: rtl/lbk_chan.sv
module lbk_chan
  import lbk_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             host_push_i,
  input  logic [DW-1:0]    host_wdata_i,
  input  logic             host_pop_i,
  output logic [DW-1:0]    host_rdata_o,
  input  logic             line_pop_i,
  output logic [DW-1:0]    line_rdata_o,
  input  logic             line_push_i,
  input  logic [DW-1:0]    line_wdata_i,
  output logic [AW:0]      tx_count_o,
  output logic [AW:0]      rx_count_o,
  output logic             tx_empty_o,
  output logic             tx_full_o,
  output logic             rx_empty_o,
  output logic             rx_full_o,
  output logic             tx_aempty_o,
  output logic             rx_afull_o,
  output logic             irq_o
);
  ctrl_t         ctrl;
  logic          tx_pop, rx_push, rx_from_tx;
  logic [DW-1:0] tx_head, rx_wdata;

  lbk_ctrl_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .ctrl_o  (ctrl)
  );

  lbk_fifo #(.DW(DW), .AW(AW)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (ctrl.tx_clr),
    .push_i  (host_push_i),
    .wdata_i (host_wdata_i),
    .pop_i   (tx_pop),
    .rdata_o (tx_head),
    .count_o (tx_count_o),
    .empty_o (tx_empty_o),
    .full_o  (tx_full_o)
  );

  lbk_xfer u_xfer (
    .loop_en_i    (ctrl.loop_en),
    .tx_clr_i     (ctrl.tx_clr),
    .rx_clr_i     (ctrl.rx_clr),
    .tx_empty_i   (tx_empty_o),
    .rx_full_i    (rx_full_o),
    .line_pop_i   (line_pop_i),
    .line_push_i  (line_push_i),
    .tx_pop_o     (tx_pop),
    .rx_push_o    (rx_push),
    .rx_from_tx_o (rx_from_tx)
  );

  assign rx_wdata     = rx_from_tx ? tx_head : line_wdata_i;
  assign line_rdata_o = tx_head;

  lbk_fifo #(.DW(DW), .AW(AW)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (ctrl.rx_clr),
    .push_i  (rx_push),
    .wdata_i (rx_wdata),
    .pop_i   (host_pop_i),
    .rdata_o (host_rdata_o),
    .count_o (rx_count_o),
    .empty_o (rx_empty_o),
    .full_o  (rx_full_o)
  );

  lbk_flags #(.AW(AW)) u_flags (
    .tx_count_i  (tx_count_o),
    .rx_count_i  (rx_count_o),
    .tx_lo_lvl_i (ctrl.tx_lo_lvl),
    .rx_hi_lvl_i (ctrl.rx_hi_lvl),
    .irq_en_i    (ctrl.irq_en),
    .irq_force_i (ctrl.irq_force),
    .tx_aempty_o (tx_aempty_o),
    .rx_afull_o  (rx_afull_o),
    .irq_o       (irq_o)
  );
endmodule

// File: rtl/lbk_chan_chk.sv
module lbk_chan_chk #(
  parameter int unsigned AW = 8
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [31:0] reg_rdata_o,
  input logic        host_push_i,
  input logic        host_pop_i,
  input logic        line_pop_i,
  input logic        line_push_i,
  input logic [AW:0] tx_count_o,
  input logic [AW:0] rx_count_o,
  input logic        tx_empty_o,
  input logic        tx_full_o,
  input logic        rx_empty_o,
  input logic        rx_full_o,
  input logic        irq_o
);
  localparam logic [AW:0] DEPTH = (AW+1)'(1 << AW);

  p_count_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_count_o <= DEPTH) && (rx_count_o <= DEPTH));

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_o && line_push_i && !reg_rdata_o[0] && !host_pop_i && !reg_we_i)
    |=> (rx_count_o == $past(rx_count_o)));

  p_no_underflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_empty_o && line_pop_i && !host_push_i && !reg_we_i)
    |=> (tx_count_o == $past(tx_count_o)));

  p_one_move_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[0] && !reg_rdata_o[31] && !reg_rdata_o[30] && !tx_empty_o &&
     !rx_full_o && !host_pop_i && !reg_we_i)
    |=> (rx_count_o == $past(rx_count_o) + 1'b1));

  p_stall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[0] && rx_full_o && !host_pop_i && !host_push_i && !reg_we_i)
    |=> $stable(tx_count_o));

  p_tx_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[30] |-> (tx_count_o == '0) && tx_empty_o && !tx_full_o);

  p_rx_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[31] |-> (rx_count_o == '0) && rx_empty_o && !rx_full_o);

  p_irq_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[1] |-> !irq_o);

  p_irq_force_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[1] && reg_rdata_o[2]) |-> irq_o);

  p_spare_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[29:28] == 2'b00) && !reg_rdata_o[3]);
endmodule

bind lbk_chan lbk_chan_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_rdata_o (reg_rdata_o),
  .host_push_i (host_push_i),
  .host_pop_i  (host_pop_i),
  .line_pop_i  (line_pop_i),
  .line_push_i (line_push_i),
  .tx_count_o  (tx_count_o),
  .rx_count_o  (rx_count_o),
  .tx_empty_o  (tx_empty_o),
  .tx_full_o   (tx_full_o),
  .rx_empty_o  (rx_empty_o),
  .rx_full_o   (rx_full_o),
  .irq_o       (irq_o)
);

// File: tb/lbk_chan_tb.sv
module lbk_chan_tb;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 8;
  localparam int NV = 6;
  localparam logic [31:0] TV_WR [NV] = '{32'hFFFF_FFFF, 32'h3000_0008, 32'h0123_4560,
                                         32'h8000_0001, 32'h4ABC_DEF6, 32'h5555_555D};
  localparam logic [31:0] TV_EX [NV] = '{32'hCFFF_FFF7, 32'h0000_0000, 32'h0123_4560,
                                         32'h8000_0001, 32'h4ABC_DEF6, 32'h4555_5555};

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [31:0]   reg_wdata_i = '0;
  logic [31:0]   reg_rdata_o;
  logic          host_push_i = 1'b0;
  logic [DW-1:0] host_wdata_i = '0;
  logic          host_pop_i = 1'b0;
  logic [DW-1:0] host_rdata_o;
  logic          line_pop_i = 1'b0;
  logic [DW-1:0] line_rdata_o;
  logic          line_push_i = 1'b0;
  logic [DW-1:0] line_wdata_i = '0;
  logic [AW:0]   tx_count_o, rx_count_o;
  logic          tx_empty_o, tx_full_o, rx_empty_o, rx_full_o;
  logic          tx_aempty_o, rx_afull_o, irq_o;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  lbk_chan #(.DW(DW), .AW(AW)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit rxc, input bit txc, input int hi,
                                     input int lo, input bit frc, input bit en, input bit lp);
    return {rxc, txc, 2'b00, hi[11:0], lo[11:0], 1'b0, frc, en, lp};
  endfunction

  task automatic wr_reg(input logic [31:0] v);
    @(negedge clk_i); reg_we_i = 1'b1; reg_wdata_i = v;
    @(negedge clk_i); reg_we_i = 1'b0;
  endtask

  task automatic h_push(input logic [31:0] d);
    @(negedge clk_i); host_push_i = 1'b1; host_wdata_i = d;
    @(negedge clk_i); host_push_i = 1'b0;
  endtask

  task automatic h_pop();
    @(negedge clk_i); host_pop_i = 1'b1;
    @(negedge clk_i); host_pop_i = 1'b0;
  endtask

  task automatic l_pop();
    @(negedge clk_i); line_pop_i = 1'b1;
    @(negedge clk_i); line_pop_i = 1'b0;
  endtask

  task automatic l_push(input logic [31:0] d);
    @(negedge clk_i); line_push_i = 1'b1; line_wdata_i = d;
    @(negedge clk_i); line_push_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 reg", reg_rdata_o, 32'h0);
    chk("R1 tx_count", 32'(tx_count_o), 0);
    chk("R1 rx_count", 32'(rx_count_o), 0);
    chk("R1 empties", {30'b0, tx_empty_o, rx_empty_o}, 32'h3);
    chk("R1 fulls", {30'b0, tx_full_o, rx_full_o}, 32'h0);
    chk("R1 irq", 32'(irq_o), 0);

    // R2 readback table
    for (int i = 0; i < NV; i++) begin
      wr_reg(TV_WR[i]);
      chk("R2 readback", reg_rdata_o, TV_EX[i]);
    end
    wr_reg(32'h0);

    // R3 hold without loopback, line drain
    wr_reg(mk(0, 0, 4, 2, 0, 0, 0));
    h_push(32'hA0); h_push(32'hA1); h_push(32'hA2);
    repeat (3) @(negedge clk_i);
    chk("R3 tx held", 32'(tx_count_o), 3);
    chk("R3 rx untouched", 32'(rx_count_o), 0);
    chk("R6 aempty 3>2", 32'(tx_aempty_o), 0);
    chk("R3 head", line_rdata_o, 32'hA0);
    l_pop();
    chk("R3 after pop", 32'(tx_count_o), 2);
    chk("R3 next head", line_rdata_o, 32'hA1);
    chk("R6 aempty 2<=2", 32'(tx_aempty_o), 1);

    // R4 loopback, one word per clock
    wr_reg(mk(0, 0, 4, 2, 0, 0, 1));
    chk("R4 no move yet", {tx_count_o, 7'b0, rx_count_o}, {9'd2, 7'b0, 9'd0});
    @(negedge clk_i);
    chk("R4 first move", {tx_count_o, 7'b0, rx_count_o}, {9'd1, 7'b0, 9'd1});
    @(negedge clk_i);
    chk("R4 second move", {tx_count_o, 7'b0, rx_count_o}, {9'd0, 7'b0, 9'd2});
    chk("R4 order a", host_rdata_o, 32'hA1);
    h_pop();
    chk("R4 order b", host_rdata_o, 32'hA2);
    h_pop();
    // R5 line push ignored in loopback
    l_push(32'h55);
    chk("R5 line push ignored", 32'(rx_count_o), 0);
    h_push(32'hC0);
    @(negedge clk_i);
    chk("R5 moved to rx", 32'(rx_count_o), 1);
    l_pop();
    chk("R5 line pop ignored", 32'(rx_count_o), 1);
    h_pop();

    // R7 overflow, R4 stall
    wr_reg(mk(0, 0, 256, 0, 0, 0, 0));
    for (int i = 0; i < 256; i++) begin
      @(negedge clk_i); line_push_i = 1'b1; line_wdata_i = i;
    end
    @(negedge clk_i); line_push_i = 1'b0;
    chk("R7 rx filled", 32'(rx_count_o), 256);
    chk("R7 rx full", 32'(rx_full_o), 1);
    chk("R6 afull 256>=256", 32'(rx_afull_o), 1);
    l_push(32'hDEAD);
    chk("R7 push dropped", 32'(rx_count_o), 256);
    chk("R7 head kept", host_rdata_o, 32'h0);
    h_push(32'hB0); h_push(32'hB1);
    wr_reg(mk(0, 0, 256, 0, 0, 0, 1));
    repeat (2) @(negedge clk_i);
    chk("R4 stall tx", 32'(tx_count_o), 2);
    chk("R4 stall rx", 32'(rx_count_o), 256);
    h_pop();
    chk("R4 space rx", 32'(rx_count_o), 255);
    chk("R6 afull 255<256", 32'(rx_afull_o), 0);
    @(negedge clk_i);
    chk("R4 resume rx", 32'(rx_count_o), 256);
    chk("R4 resume tx", 32'(tx_count_o), 1);
    chk("R4 head after resume", host_rdata_o, 32'h1);

    // R8 queue clears
    wr_reg(mk(1, 1, 256, 0, 0, 0, 0));
    chk("R8 counts", {tx_count_o, 7'b0, rx_count_o}, 32'h0);
    chk("R8 flags", {28'b0, tx_empty_o, rx_empty_o, tx_full_o, rx_full_o}, 32'hC);
    h_push(32'hE0);
    chk("R8 push ignored", 32'(tx_count_o), 0);
    wr_reg(mk(0, 0, 4, 2, 0, 0, 0));
    chk("R8 released empty", {tx_count_o, 7'b0, rx_count_o}, 32'h0);

    // R7 underflow
    h_pop();
    chk("R7 rx pop empty", 32'(rx_count_o), 0);
    l_pop();
    chk("R7 tx pop empty", 32'(tx_count_o), 0);

    // R9 interrupt gating
    wr_reg(mk(0, 0, 4, 0, 1, 0, 0));
    chk("R9 masked force", 32'(irq_o), 0);
    h_push(32'h77);
    wr_reg(mk(0, 0, 4, 0, 0, 1, 0));
    chk("R9 no source", 32'(irq_o), 0);
    wr_reg(mk(0, 0, 4, 0, 1, 1, 0));
    chk("R9 force", 32'(irq_o), 1);
    wr_reg(mk(0, 0, 0, 0, 0, 1, 0));
    chk("R9 afull source", 32'(irq_o), 1);
    wr_reg(mk(0, 0, 4, 1, 0, 1, 0));
    chk("R9 aempty source", 32'(irq_o), 1);

    finish_run();
  end
endmodule